// File: doc/BRIEF.md
# Receive Frame Acceptance Filter

This block sits between a byte-wide Ethernet receive path (preamble already removed) and the receive FIFO. It watches each frame as it streams in, compares the destination address against a programmed station address, runs a CRC-32 check over the whole frame including the frame check sequence, and then gives a one-cycle verdict telling the FIFO writer to keep or discard the frame it has just buffered.

A frame with a bad CRC can also trigger a harsher response. When the reject-on-bad-CRC control is set, the frame is discarded, the whole receive FIFO is flushed, and a sticky receive-error flag is raised for an interrupt. Software can also ask for a FIFO flush through a clear bit. The flush is only carried out while the receiver is disabled, and the bit reads back as 1 until the register holding it is read.

Top module: `rx_frame_filter`

## Requirements
- R1: When `rx_en_i` is 0 at a frame's start byte, that frame produces no commit, no drop, no flush and no error.
- R2: With promiscuous mode off, a frame whose first destination byte has bit 0 clear is committed only if destination byte k (k = 0 first on the wire) equals `station_addr_i[8k+7:8k]`, and is dropped otherwise.
- R3: With promiscuous mode on, every frame with a complete destination address and no CRC rejection is committed, whatever its address.
- R4: A frame is multicast when bit 0 of its first destination byte is 1, and the all-ones broadcast address counts as multicast. With promiscuous mode off, such a frame is committed only when `mcast_en_i` is 1.
- R5: CRC-32 (polynomial 0x04C11DB7, bit-reflected, initial value all ones) runs over every byte from the destination address through the FCS. A correct frame leaves the residue 0xC704DD7B, which is 0xDEBB20E3 in the reflected register. With reject enabled, a frame with any other residue is dropped, `flush_o` pulses, and `rx_err_o` rises in the verdict cycle. `rx_err_o` then stays 1 until `err_clr_i` is sampled high.
- R6: With reject disabled, a bad CRC changes neither the verdict nor `flush_o` nor `rx_err_o`.
- R7: The verdict appears exactly in the cycle after the end-of-frame byte is sampled and lasts one cycle. `commit_o` and `drop_o` are never high together. A frame shorter than six bytes is dropped because its destination address is incomplete.
- R8: `promisc_i`, `mcast_en_i`, `crc_reject_i` and `rx_en_i` are sampled at the start byte. Changing them mid-frame does not alter that frame's verdict.
- R9: A sampled `fifo_clr_wr_i` sets the clear bit. One cycle after the bit is seen set while `rx_en_i` is 0, `flush_o` pulses once for that request. While `rx_en_i` is 1 the flush waits.
- R10: `fifo_clr_bit_o` reads 1 from the cycle after the write until a sampled `cfg_rd_i` without a write returns it to 0.
- R11: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Byte on `rx_data_i` is valid |
| rx_sof_i | input | 1 | Valid byte is the first of a frame |
| rx_eof_i | input | 1 | Valid byte is the last FCS byte of a frame |
| rx_data_i | input | 8 | Receive byte |
| station_addr_i | input | 48 | Station address, byte k in bits 8k+7:8k |
| rx_en_i | input | 1 | Receiver enable |
| promisc_i | input | 1 | Accept any destination |
| mcast_en_i | input | 1 | Accept multicast and broadcast |
| crc_reject_i | input | 1 | Reject, flush and flag on bad CRC |
| fifo_clr_wr_i | input | 1 | Write of 1 to the FIFO clear bit |
| cfg_rd_i | input | 1 | Read of the register holding the clear bit |
| err_clr_i | input | 1 | Clears the receive-error flag |
| fifo_clr_bit_o | output | 1 | Clear bit read value |
| commit_o | output | 1 | Keep the frame just received |
| drop_o | output | 1 | Discard the frame just received |
| flush_o | output | 1 | Flush the whole receive FIFO |
| rx_err_o | output | 1 | Sticky receive-error flag |

## Verification
The assertions check on every cycle the properties that hold at any time. A verdict only follows a sampled end-of-frame byte, and a frame started with the receiver off never yields one. The error flag rises only alongside a drop with a flush and stays up until it is cleared. The latched mode bits hold steady inside a frame, a clear-driven flush never follows a cycle with the receiver enabled, and a read clears the clear bit. Other behaviour can only be shown by the bench's scenarios, which compare every output against a behavioural model on every clock. These scenarios cover the address decisions under each mode combination, CRC rejection against tolerance, short frames, a mode change in mid-frame, and a deferred flush.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT      = 32'hFFFFFFFF;
  // good-frame residue as held in the reflected register
  localparam logic [31:0] CRC_RESIDUE   = 32'hDEBB20E3;

  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/rx_crc_acc.sv
module rx_crc_acc import rxf_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic       start_i,
  input  logic [7:0] data_i,
  output logic       crc_ok_o
);
  logic [31:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) crc_q <= CRC_INIT;
    else if (step_i) crc_q <= crc32_step(start_i ? CRC_INIT : crc_q, data_i);
  end

  assign crc_ok_o = (crc_q == CRC_RESIDUE);
endmodule

// File: rtl/rx_da_check.sv
module rx_da_check #(
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    step_i,
  input  logic                    start_i,
  input  logic [7:0]              data_i,
  input  logic [8*ADDR_BYTES-1:0] station_i,
  output logic                    full_o,
  output logic                    match_o,
  output logic                    group_o
);
  localparam int CW = $clog2(ADDR_BYTES + 1);

  logic [CW-1:0] cnt_q, idx;
  logic          match_q, group_q, in_da;
  logic [7:0]    exp_byte;

  assign idx   = start_i ? '0 : cnt_q;
  assign in_da = idx < CW'(ADDR_BYTES);

  always_comb begin
    exp_byte = '0;
    for (int k = 0; k < ADDR_BYTES; k++)
      if (idx == CW'(k)) exp_byte = station_i[8*k +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      match_q <= 1'b0;
      group_q <= 1'b0;
    end else if (step_i) begin
      if (in_da) begin
        cnt_q   <= idx + 1'b1;
        match_q <= (start_i | match_q) & (data_i == exp_byte);
      end
      if (start_i) group_q <= data_i[0];
    end
  end

  assign full_o  = (cnt_q == CW'(ADDR_BYTES));
  assign match_o = match_q;
  assign group_o = group_q;

  assert_da_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(ADDR_BYTES));
endmodule

// File: rtl/rx_flush_ctrl.sv
module rx_flush_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_wr_i,
  input  logic cfg_rd_i,
  input  logic rx_en_i,
  output logic clr_bit_o,
  output logic flush_o
);
  logic bit_q, done_q, pulse_q, fire;

  assign fire = bit_q & ~done_q & ~rx_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q   <= 1'b0;
      done_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fire;
      if (clr_wr_i) begin
        bit_q  <= 1'b1;
        done_q <= 1'b0;
      end else if (cfg_rd_i) begin
        bit_q  <= 1'b0;
        done_q <= 1'b0;
      end else if (fire) begin
        done_q <= 1'b1;
      end
    end
  end

  assign clr_bit_o = bit_q;
  assign flush_o   = pulse_q;

  assert_clr_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> !$past(rx_en_i));
  assert_clr_selfclear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rd_i && !clr_wr_i) |=> !bit_q);
endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter import rxf_pkg::*; #(
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rx_valid_i,
  input  logic                    rx_sof_i,
  input  logic                    rx_eof_i,
  input  logic [7:0]              rx_data_i,
  input  logic [8*ADDR_BYTES-1:0] station_addr_i,
  input  logic                    rx_en_i,
  input  logic                    promisc_i,
  input  logic                    mcast_en_i,
  input  logic                    crc_reject_i,
  input  logic                    fifo_clr_wr_i,
  input  logic                    cfg_rd_i,
  input  logic                    err_clr_i,
  output logic                    fifo_clr_bit_o,
  output logic                    commit_o,
  output logic                    drop_o,
  output logic                    flush_o,
  output logic                    rx_err_o
);
  logic in_frame_q, done_q, prm_q, mce_q, rej_q, err_q;
  logic start, step, fin;
  logic crc_ok, da_full, da_match, da_group;
  logic crc_bad, addr_ok, keep, clr_flush;

  assign start = rx_valid_i & rx_sof_i & rx_en_i;
  assign step  = rx_valid_i & (rx_sof_i ? rx_en_i : in_frame_q);
  assign fin   = step & rx_eof_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      done_q     <= 1'b0;
      prm_q      <= 1'b0;
      mce_q      <= 1'b0;
      rej_q      <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= fin;
      if (rx_valid_i & rx_sof_i) in_frame_q <= rx_en_i & ~rx_eof_i;
      else if (fin)              in_frame_q <= 1'b0;
      if (start) begin
        prm_q <= promisc_i;
        mce_q <= mcast_en_i;
        rej_q <= crc_reject_i;
      end
      err_q <= (err_q & ~err_clr_i) | crc_bad;
    end
  end

  rx_crc_acc u_crc (
    .clk_i, .rst_ni,
    .step_i   (step),
    .start_i  (rx_sof_i),
    .data_i   (rx_data_i),
    .crc_ok_o (crc_ok)
  );

  rx_da_check #(.ADDR_BYTES(ADDR_BYTES)) u_da (
    .clk_i, .rst_ni,
    .step_i    (step),
    .start_i   (rx_sof_i),
    .data_i    (rx_data_i),
    .station_i (station_addr_i),
    .full_o    (da_full),
    .match_o   (da_match),
    .group_o   (da_group)
  );

  rx_flush_ctrl u_clr (
    .clk_i, .rst_ni,
    .clr_wr_i  (fifo_clr_wr_i),
    .cfg_rd_i  (cfg_rd_i),
    .rx_en_i   (rx_en_i),
    .clr_bit_o (fifo_clr_bit_o),
    .flush_o   (clr_flush)
  );

  assign crc_bad  = done_q & rej_q & ~crc_ok;
  assign addr_ok  = da_full & (prm_q | (da_group ? mce_q : da_match));
  assign keep     = ~crc_bad & addr_ok;
  assign commit_o = done_q & keep;
  assign drop_o   = done_q & ~keep;
  assign flush_o  = clr_flush | crc_bad;
  assign rx_err_o = err_q | crc_bad;

  assert_verdict_after_eof_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o || drop_o) |-> $past(rx_valid_i && rx_eof_i));
  assert_off_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_sof_i && !rx_en_i) |=> !(commit_o || drop_o));
  assert_err_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(drop_o && flush_o));
  assert_err_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_err_o && !err_clr_i) |=> rx_err_o);
  assert_cfg_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_frame_q && !(rx_valid_i && rx_sof_i)) |=> ($stable(prm_q) && $stable(mce_q) && $stable(rej_q)));
endmodule

// File: tb/rx_frame_filter_test.sv
`timescale 1ns/1ps
module rx_frame_filter_test;
  localparam logic [47:0] STATION = 48'h0A0908070602;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0;
  logic [7:0] rx_data = '0;
  logic rx_en = 0, promisc = 0, mcast_en = 0, crc_reject = 0;
  logic fifo_clr_wr = 0, cfg_rd = 0, err_clr = 0;
  logic fifo_clr_bit, commit, drop, flush, rx_err;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R11";
  logic [7:0] tx_q[$];

  always #2.5 clk = ~clk;

  rx_frame_filter uut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_valid_i(rx_valid), .rx_sof_i(rx_sof),
    .rx_eof_i(rx_eof), .rx_data_i(rx_data), .station_addr_i(STATION),
    .rx_en_i(rx_en), .promisc_i(promisc), .mcast_en_i(mcast_en),
    .crc_reject_i(crc_reject), .fifo_clr_wr_i(fifo_clr_wr), .cfg_rd_i(cfg_rd),
    .err_clr_i(err_clr), .fifo_clr_bit_o(fifo_clr_bit), .commit_o(commit),
    .drop_o(drop), .flush_o(flush), .rx_err_o(rx_err)
  );

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ 32'hEDB88320;
      else r = r >> 1;
    end
    return r;
  endfunction

  // ---- behavioural reference model ----
  logic [7:0] m_q[$];
  bit m_act, m_prm, m_mce, m_rej;
  bit m_commit, m_drop, m_bad, m_err_reg, m_bit, m_done, m_fl;

  task automatic m_decide();
    int n = m_q.size();
    logic [31:0] c = 32'hFFFFFFFF;
    bit crc_ok, full, grp, match, acc;
    for (int i = 0; i < n - 4; i++) c = ref_crc(c, m_q[i]);
    c = ~c;
    crc_ok = (n >= 4) && ({m_q[n-1], m_q[n-2], m_q[n-3], m_q[n-4]} == c);
    full = n >= 6;
    grp = m_q[0][0];
    match = full;
    for (int k = 0; k < 6 && k < n; k++) if (m_q[k] != STATION[8*k +: 8]) match = 0;
    if (m_prm) acc = full;
    else if (grp) acc = full && m_mce;
    else acc = match;
    m_bad = m_rej && !crc_ok;
    m_commit = !m_bad && acc;
    m_drop = !m_commit;
  endtask

  task automatic chk(input string sig, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", cur_req, sig, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit f;
    if (!rst_ni) begin
      m_q.delete(); m_act = 0; m_commit = 0; m_drop = 0; m_bad = 0;
      m_err_reg = 0; m_bit = 0; m_done = 0; m_fl = 0;
    end else begin
      m_err_reg = (m_err_reg && !err_clr) || m_bad;
      m_commit = 0; m_drop = 0; m_bad = 0;
      f = m_bit && !m_done && !rx_en;
      if (fifo_clr_wr) begin m_bit = 1; m_done = 0; end
      else if (cfg_rd) begin m_bit = 0; m_done = 0; end
      else if (f) m_done = 1;
      m_fl = f;
      if (rx_valid) begin
        if (rx_sof) begin
          m_act = rx_en; m_q.delete();
          if (rx_en) begin m_prm = promisc; m_mce = mcast_en; m_rej = crc_reject; end
        end
        if (m_act) begin
          m_q.push_back(rx_data);
          if (rx_eof) begin m_decide(); m_act = 0; end
        end
      end
    end
    #1;
    if (rst_ni) begin
      chk("commit_o", commit, m_commit);
      chk("drop_o", drop, m_drop);
      chk("flush_o", flush, m_fl || m_bad);
      chk("rx_err_o", rx_err, m_err_reg || m_bad);
      chk("fifo_clr_bit_o", fifo_clr_bit, m_bit);
    end
  end

  // ---- stimulus ----
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [47:0] da, input int pay);
    for (int k = 0; k < 6; k++) tx_q.push_back(da[8*k +: 8]);
    for (int i = 0; i < pay; i++) tx_q.push_back(8'(8'h30 + i));
  endtask

  task automatic send(input bit corrupt, input int chg_at, input bit chg_prm);
    logic [31:0] c = 32'hFFFFFFFF;
    int n;
    foreach (tx_q[i]) c = ref_crc(c, tx_q[i]);
    c = ~c;
    for (int b = 0; b < 4; b++) tx_q.push_back(c[8*b +: 8]);
    n = tx_q.size();
    if (corrupt) tx_q[n-1] = tx_q[n-1] ^ 8'h40;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == chg_at) promisc = chg_prm;
      rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == n - 1); rx_data = tx_q[i];
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0;
    tx_q.delete();
    idle(1);
  endtask

  task automatic pulse_err_clr();
    @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    idle(3);
    // R11: reset state
    cur_req = "R11";
    chk("commit_o", commit, 0); chk("drop_o", drop, 0); chk("flush_o", flush, 0);
    chk("rx_err_o", rx_err, 0); chk("fifo_clr_bit_o", fifo_clr_bit, 0);
    rst_ni = 1;
    idle(2);
    rx_en = 1; crc_reject = 1;

    cur_req = "R2";  // unicast match / mismatch
    load(STATION, 4); send(0, -1, 0);
    load(48'h0A0908070604, 4); send(0, -1, 0);
    load(48'h1A0908070602, 2); send(0, -1, 0);

    cur_req = "R1";  // receiver off: frame ignored
    rx_en = 0; load(STATION, 4); send(0, -1, 0); rx_en = 1;

    cur_req = "R3";  // promiscuous
    promisc = 1; load(48'h223344556670, 3); send(0, -1, 0);
    load(48'hFFFFFFFFFF01, 3); send(0, -1, 0); promisc = 0;

    cur_req = "R4";  // multicast and broadcast
    load(48'h5E0000000001, 4); send(0, -1, 0);
    mcast_en = 1; load(48'h5E0000000001, 4); send(0, -1, 0);
    load(48'hFFFFFFFFFFFF, 4); send(0, -1, 0);
    mcast_en = 0; load(48'hFFFFFFFFFFFF, 4); send(0, -1, 0);

    cur_req = "R6";  // bad CRC tolerated
    crc_reject = 0; load(STATION, 4); send(1, -1, 0); crc_reject = 1;

    cur_req = "R5";  // bad CRC rejected, flush, sticky error
    load(STATION, 4); send(1, -1, 0);
    idle(4);
    load(STATION, 2); send(0, -1, 0);
    pulse_err_clr(); idle(2);

    cur_req = "R7";  // short frame and back-to-back
    tx_q.push_back(8'h02); send(0, -1, 0);
    load(STATION, 0); send(0, -1, 0);
    load(48'h0A0908070603, 0); send(0, -1, 0);

    cur_req = "R8";  // mid-frame control change ignored
    load(48'h223344556670, 4); send(0, 3, 1);
    promisc = 0;
    load(STATION, 4); send(0, 2, 0);
    promisc = 1; load(48'h223344556670, 4); send(0, 3, 0);
    promisc = 0;

    cur_req = "R9";  // clear deferred while receiving
    @(negedge clk); fifo_clr_wr = 1; @(negedge clk); fifo_clr_wr = 0;
    idle(5);
    rx_en = 0; idle(4);
    cur_req = "R10"; // read self-clears the bit
    @(negedge clk); cfg_rd = 1; @(negedge clk); cfg_rd = 0;
    idle(3);
    cur_req = "R9";
    @(negedge clk); fifo_clr_wr = 1; @(negedge clk); fifo_clr_wr = 0;
    idle(4);
    cur_req = "R10";
    @(negedge clk); cfg_rd = 1; @(negedge clk); cfg_rd = 0;
    idle(3);
    rx_en = 1; load(STATION, 4); send(0, -1, 0);
    idle(3);
    summary();
  end
endmodule